// File: doc/BRIEF.md
# Linked Breakpoint Comparator Unit

This block holds a small set of breakpoint slots and watches the instruction stream. Each slot is a pair made of a 32-bit value register and a control register. Software programs the slots through a single-cycle register port. On every cycle the block tests each enabled slot against the current instruction address, or, for the slots able to do so, against the current context identifier. It raises a debug-event pulse when a breakpoint condition holds.

Only the two highest slots can compare a context identifier. An address slot can be tied to one of those slots through its control register. A tied address slot fires only when its own address match and the partner's context match are both true in the same cycle. The partner slot then serves only as a qualifier and never fires on its own.

The event output is registered. It reflects the compare inputs of the previous cycle, gated by an instruction-valid strobe.

Top module: `brk_link_unit`

## Requirements
- R1: After reset every value and control register reads 0 and `dbg_event` is low.
- R2: The value register of slot n is at byte offset 0x100+4n and its control register is at 0x140+4n, for n from 0 to 5. A read of any other offset returns 0, and a write to any other offset changes no register.
- R3: Value registers are 32 bits. In slots 0 to 3, bits [1:0] read as 0 and writes to them are dropped. Slots 4 and 5 keep all 32 bits.
- R4: Control register fields are: bit 0 enable, bit 1 context mode, bit 2 link enable, bits [6:4] partner index. All other bits read as 0. Bit 1 reads as 0 in slots 0 to 3, so those slots always compare addresses.
- R5: An enabled slot in address mode matches when bits [31:2] of its value equal bits [31:2] of `iva`.
- R6: An enabled slot 4 or 5 in context mode matches when all 32 bits of its value equal `ctxid`.
- R7: `dbg_event` is high in the cycle after an edge at which `iv_valid` was high and at least one qualified slot matched. Otherwise it is low.
- R8: A slot with link enable set qualifies only when its own match and its partner's match are true in the same cycle. The partner must be slot 4 or 5, enabled, and in context mode.
- R9: A slot that is named as partner by another enabled slot with link enable set never fires on its own match.
- R10: A link whose partner index points at slot 0 to 3, at the slot itself, or at index 6 or 7 never matches.
- R11: A slot whose enable bit is 0 contributes to no event, whatever its other fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| iva | input | 32 | Current instruction address |
| ctxid | input | 32 | Current context identifier |
| iv_valid | input | 1 | The instruction on `iva` is valid this cycle |
| dbg_event | output | 1 | Registered debug-event pulse |

## Verification
The bench builds the block with its default parameters: six slots, of which the top two handle context IDs, and a 3-bit partner field. This makes every mapping case reachable. The bench can link to a context-capable slot, to an address-only slot, to the slot itself, and to the indices 6 and 7, which lie past the last slot. With these defaults the low-bit masking of the address-only slots and the ignored context bit on them can both be observed through register reads and events. A randomized phase mixes links, modes and inputs from small value pools so that coincident matches occur often.

// File: rtl/brk_link_unit.sv
module brk_link_unit #(
  parameter int NUM_BRP  = 6,
  parameter int NUM_CTX  = 2,
  parameter int RAW      = 12,
  parameter int VAL_BASE = 'h100,
  parameter int CTL_BASE = 'h140
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RAW-1:0]  reg_addr,
  input  logic            reg_we,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic [31:0]     iva,
  input  logic [31:0]     ctxid,
  input  logic            iv_valid,
  output logic            dbg_event
);
  localparam int FIRST_CTX = NUM_BRP - NUM_CTX;

  logic [31:0] val_q [NUM_BRP];
  logic [31:0] ctl_q [NUM_BRP];
  logic [NUM_BRP-1:0] val_sel, ctl_sel, en, lnk, raw_hit, partner_ok, consumed, qual;

  function automatic logic [31:0] vmask(int n);
    return (n >= FIRST_CTX) ? 32'hFFFF_FFFF : 32'hFFFF_FFFC;
  endfunction

  function automatic logic [31:0] cmask(int n);
    return (n >= FIRST_CTX) ? 32'h0000_0077 : 32'h0000_0075;
  endfunction

  for (genvar n = 0; n < NUM_BRP; n++) begin : g_pair
    assign val_sel[n] = (reg_addr == RAW'(VAL_BASE + 4*n));
    assign ctl_sel[n] = (reg_addr == RAW'(CTL_BASE + 4*n));
    assign en[n]      = ctl_q[n][0];
    assign lnk[n]     = ctl_q[n][2];
    assign raw_hit[n] = en[n] & (ctl_q[n][1] ? (val_q[n] == ctxid)
                                             : (val_q[n][31:2] == iva[31:2]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int n = 0; n < NUM_BRP; n++) begin
        val_q[n] <= '0;
        ctl_q[n] <= '0;
      end
    end else if (reg_we) begin
      for (int n = 0; n < NUM_BRP; n++) begin
        if (val_sel[n]) val_q[n] <= reg_wdata & vmask(n);
        if (ctl_sel[n]) ctl_q[n] <= reg_wdata & cmask(n);
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int n = 0; n < NUM_BRP; n++) begin
      if (val_sel[n]) reg_rdata = val_q[n];
      if (ctl_sel[n]) reg_rdata = ctl_q[n];
    end
  end

  always_comb begin
    partner_ok = '0;
    consumed   = '0;
    for (int n = 0; n < NUM_BRP; n++) begin
      for (int m = 0; m < NUM_BRP; m++) begin
        if (m != n && ctl_q[n][6:4] == 3'(m)) begin
          if (m >= FIRST_CTX && ctl_q[m][1] && raw_hit[m]) partner_ok[n] = 1'b1;
          if (en[n] && lnk[n]) consumed[m] = 1'b1;
        end
      end
    end
  end

  assign qual = raw_hit & ~consumed & (~lnk | partner_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbg_event <= 1'b0;
    else        dbg_event <= iv_valid & (|qual);
  end

  // R7
  ev_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_event |-> $past(iv_valid));

  // R11
  idle_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |=> !dbg_event);

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|val_sel[FIRST_CTX-1:0]) |-> (reg_rdata[1:0] == 2'b00));

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|{val_sel, ctl_sel}) |-> (reg_rdata == '0));

  // R4
  ctl_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ctl_sel) |-> ((reg_rdata & ~32'h77) == '0));
endmodule

// File: tb/brk_link_unit_test.sv
module brk_link_unit_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] iva = '0;
  logic [31:0] ctxid = '0;
  logic        iv_valid = 1'b0;
  logic        dbg_event;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";
  logic [31:0] mval [6];
  logic [31:0] mctl [6];
  bit exp_ev = 1'b0;
  bit armed = 1'b0;

  brk_link_unit uut (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mread(logic [11:0] a);
    if (a >= 12'h100 && a <= 12'h114 && a[1:0] == 2'b00) return mval[(a - 12'h100) / 4];
    if (a >= 12'h140 && a <= 12'h154 && a[1:0] == 2'b00) return mctl[(a - 12'h140) / 4];
    return 32'h0;
  endfunction

  function automatic bit slot_match(int p);
    if (!mctl[p][0]) return 1'b0;
    if (mctl[p][1]) return mval[p] == ctxid;
    return (mval[p] >> 2) == (iva >> 2);
  endfunction

  function automatic bit is_target(int p);
    for (int q = 0; q < 6; q++)
      if (q != p && mctl[q][0] && mctl[q][2] && int'(mctl[q][6:4]) == p) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit model_fire();
    if (!iv_valid) return 1'b0;
    for (int p = 0; p < 6; p++) begin
      int t;
      if (!slot_match(p) || is_target(p)) continue;
      if (!mctl[p][2]) return 1'b1;
      t = int'(mctl[p][6:4]);
      if (t == p || t < 4 || t > 5) continue;
      if (mctl[t][1] && slot_match(t)) return 1'b1;
    end
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_ev <= 1'b0;
      for (int p = 0; p < 6; p++) begin mval[p] <= '0; mctl[p] <= '0; end
    end else begin
      exp_ev <= model_fire();
      if (reg_we) begin
        if (reg_addr >= 12'h100 && reg_addr <= 12'h114 && reg_addr[1:0] == 2'b00)
          mval[(reg_addr - 12'h100) / 4] <= reg_wdata & (((reg_addr - 12'h100) / 4 < 4) ? 32'hFFFF_FFFC : 32'hFFFF_FFFF);
        if (reg_addr >= 12'h140 && reg_addr <= 12'h154 && reg_addr[1:0] == 2'b00)
          mctl[(reg_addr - 12'h140) / 4] <= reg_wdata & (((reg_addr - 12'h140) / 4 < 4) ? 32'h75 : 32'h77);
      end
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      checks++;
      if (dbg_event !== exp_ev) begin
        errors++;
        $display("FAIL %s dbg_event: actual %0b expected %0b at %0t", cur_req, dbg_event, exp_ev, $time);
      end
      checks++;
      if (reg_rdata !== mread(reg_addr)) begin
        errors++;
        $display("FAIL %s reg_rdata@%h: actual %h expected %h", cur_req, reg_addr, reg_rdata, mread(reg_addr));
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1; step(); reg_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a);
    reg_addr = a; step();
  endtask

  task automatic drive(logic [31:0] a, logic [31:0] c, logic v);
    iva = a; ctxid = c; iv_valid = v; step();
  endtask

  task automatic clear_all();
    for (int p = 0; p < 6; p++) begin wr(12'h140 + 12'(4*p), 0); wr(12'h100 + 12'(4*p), 0); end
  endtask

  initial begin
    #(PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1; armed = 1'b1;

    cur_req = "R1";
    for (int p = 0; p < 6; p++) begin rd(12'h100 + 12'(4*p)); rd(12'h140 + 12'(4*p)); end

    cur_req = "R3";
    for (int p = 0; p < 6; p++) begin wr(12'h100 + 12'(4*p), 32'hDEAD_BEEF ^ p); rd(12'h100 + 12'(4*p)); end

    cur_req = "R4";
    for (int p = 0; p < 6; p++) begin wr(12'h140 + 12'(4*p), 32'hFFFF_FF00 | 32'h7E); rd(12'h140 + 12'(4*p)); end

    cur_req = "R2";
    wr(12'h118, 32'h1234_5678); wr(12'h158, 32'hFFFF_FFFF); wr(12'h000, 32'h1); wr(12'h102, 32'h5);
    rd(12'h118); rd(12'h13C); rd(12'h158); rd(12'h102); rd(12'h100); rd(12'h140); rd(12'h154);
    clear_all();

    cur_req = "R11";
    wr(12'h100, 32'h1000); wr(12'h140, 32'h0);
    drive(32'h1000, 0, 1); drive(32'h1000, 0, 1);

    cur_req = "R5";
    wr(12'h140, 32'h1);
    drive(32'h1000, 0, 1); drive(32'h1003, 0, 1); drive(32'h1004, 0, 1); drive(32'h0FFC, 0, 1);
    cur_req = "R7";
    drive(32'h1000, 0, 0); drive(32'h1000, 0, 1); drive(32'h2000, 0, 1); step();
    cur_req = "R4";
    wr(12'h140, 32'h3);
    drive(32'h1000, 32'h1000, 1); drive(32'h2000, 32'h1000, 1);
    clear_all();

    cur_req = "R6";
    wr(12'h110, 32'hABCD_1236); wr(12'h150, 32'h3);
    drive(0, 32'hABCD_1236, 1); drive(0, 32'hABCD_1237, 1); drive(32'hABCD_1236, 0, 1); drive(0, 32'hABCD_1236, 0);

    cur_req = "R8";
    wr(12'h104, 32'h2000); wr(12'h144, 32'h45);
    drive(32'h2000, 32'hABCD_1236, 1); drive(32'h2000, 32'h0, 1);
    drive(32'h3000, 32'hABCD_1236, 1); drive(32'h2002, 32'hABCD_1236, 1);
    cur_req = "R9";
    drive(32'h3000, 32'hABCD_1236, 1); drive(32'h3000, 32'hABCD_1236, 1);
    cur_req = "R8";
    wr(12'h150, 32'h1);
    drive(32'h2000, 32'hABCD_1236, 1); drive(32'h2000, 32'h2000, 1);

    cur_req = "R10";
    clear_all();
    wr(12'h100, 32'h4000); wr(12'h108, 32'h4000);
    wr(12'h148, 32'h1); wr(12'h140, 32'h25);
    drive(32'h4000, 0, 1); drive(32'h4000, 0, 1);
    wr(12'h140, 32'h65); drive(32'h4000, 0, 1);
    wr(12'h140, 32'h75); drive(32'h4000, 0, 1);
    wr(12'h114, 32'h77); wr(12'h154, 32'h57);
    drive(32'h4000, 32'h77, 1); drive(32'h74, 32'h77, 1);
    clear_all();

    cur_req = "R8";
    for (int i = 0; i < 3000; i++) begin
      int sel = $urandom_range(0, 3);
      if (sel == 0) begin
        logic [31:0] pool [4] = '{32'h1000, 32'h2000, 32'hC0DE_0001, 32'hC0DE_0002};
        wr(12'h100 + 12'(4 * $urandom_range(0, 5)), pool[$urandom_range(0, 3)] | $urandom_range(0, 3));
      end else if (sel == 1) begin
        wr(12'h140 + 12'(4 * $urandom_range(0, 5)), $urandom());
      end else begin
        logic [31:0] ipool [4] = '{32'h1000, 32'h1002, 32'h2000, 32'h3000};
        logic [31:0] cpool [3] = '{32'hC0DE_0001, 32'hC0DE_0002, 32'h1000};
        reg_addr = 12'h100 + 12'(4 * $urandom_range(0, 17));
        drive(ipool[$urandom_range(0, 3)], cpool[$urandom_range(0, 2)], 1'($urandom_range(0, 3) != 0));
      end
    end
    step(); step();

    armed = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule